// File: doc/BRIEF.md
# Bit-Matrix Transpose and Bit Gather Unit

This unit performs one of two bit permutations on 64-bit operands, chosen by a one-bit opcode. In transpose mode, operand `a` is viewed as an 8x8 bit matrix in which each byte is one row, and the unit returns the transpose of that matrix. In gather mode, each of the eight bytes of operand `b` is an independent bit index into `a`. The eight bits picked this way form the low byte of the result.

An operation is issued by raising `start` for one clock cycle, with `op`, `a` and `b` valid in that cycle. The result is registered. It appears one cycle later, together with a one-cycle `done` pulse, and then holds until the next issue. The matrix side is the parameter `DIM`, which must be 4 or more. The data width is `DIM*DIM` and each index field is `DIM` bits wide. The default is `DIM` = 8, which gives 64-bit operands with byte-wide indices.

Top module: `bmx_top`

## Requirements
- R1: While `rstN` is low, and after it rises until the first issue, `result` is all zeros and `done` is 0.
- R2: `done` is 1 in exactly the cycle after a cycle with `start`=1, and 0 in every other cycle.
- R3: With `op`=0 (transpose), the result bit at position 8*j+i equals input bit `a[8*i+j]` for all i, j in 0..7. Bit 0 is the LSB and byte 0 is bits 7:0.
- R4: Transposing a value and then transposing the result gives back the original value.
- R5: With `op`=1 (gather), result bit k (k in 0..7) equals `a[b[8*k+7:8*k]]` when that index byte is below 64.
- R6: In gather mode, an index byte with a value of 64 to 255 makes its result bit 0.
- R7: In gather mode, result bits 63:8 are 0.
- R8: In a cycle with `start`=0, `result` keeps its value, whatever `a`, `b` and `op` do.
- R9: In transpose mode, `b` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue strobe: `op`, `a` and `b` are captured in this cycle |
| op | input | 1 | 0 = matrix transpose, 1 = bit gather |
| a | input | 64 | Matrix (transpose) or bit source (gather) |
| b | input | 64 | Eight index bytes (gather only) |
| done | output | 1 | One-cycle pulse: `result` is updated |
| result | output | 64 | Registered permutation result |

## Verification
The hardest case to reach from the ports is a gather in which in-range and out-of-range index bytes share one `b` word. This matters most when an out-of-range byte has low six bits that point at a set bit of `a`, because a decoder that drops the upper index bits would then return a 1 instead of 0. The bench builds such words on purpose. It sets `a` to all ones, sets index bytes to 64, 127, 128 and 255 (all aliasing in-range positions), and fills the remaining bytes with random mixes of both kinds. It checks every lane against a loop model. Transpose is checked with fixed patterns whose transposes are easy to verify, and with the double-transpose identity on random values.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

  typedef enum logic {
    OP_XPOSE  = 1'b0,
    OP_GATHER = 1'b1
  } bmxOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRes;    // capture a new result this edge
    logic pickGather; // 1: gather network, 0: transpose network
  } bmxCtrl_t;

endpackage

// File: rtl/bmx_ctrl.sv
module bmx_ctrl
  import bmx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  bmxOp_e   opCode,
  output bmxCtrl_t ctrl,
  output logic     doneQ
);

  always_comb begin
    ctrl.loadRes    = start;
    ctrl.pickGather = (opCode == OP_GATHER);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= start;
  end

endmodule

// File: rtl/bmx_datapath.sv
module bmx_datapath
  import bmx_pkg::*;
#(
  parameter int DIM = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bmxCtrl_t          ctrl,
  input  logic [DIM*DIM-1:0] srcA,
  input  logic [DIM*DIM-1:0] srcB,
  output logic [DIM*DIM-1:0] resQ
);

  localparam int DATA_W = DIM * DIM;
  localparam int IDX_W  = $clog2(DATA_W);

  logic [DATA_W-1:0] xposeW;
  logic [DIM-1:0]    pickedW;
  logic [DATA_W-1:0] gatherW;

  // transpose: row r, column c -> row c, column r
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      assign xposeW[c*DIM + r] = srcA[r*DIM + c];
    end
  end

  // gather: one lane per index field
  for (genvar k = 0; k < DIM; k++) begin : g_lane
    logic [DIM-1:0] idx;
    logic           inRange;
    assign idx = srcB[k*DIM +: DIM];
    if (DIM > IDX_W) begin : g_hiChk
      if (DATA_W == (1 << IDX_W)) begin : g_pow2
        assign inRange = ~|idx[DIM-1:IDX_W];
      end else begin : g_npow2
        assign inRange = (~|idx[DIM-1:IDX_W]) && (int'(idx[IDX_W-1:0]) < DATA_W);
      end
    end else begin : g_noHi
      if (DATA_W == (1 << IDX_W)) begin : g_pow2
        assign inRange = 1'b1;
      end else begin : g_npow2
        assign inRange = (int'(idx[IDX_W-1:0]) < DATA_W);
      end
    end
    assign pickedW[k] = inRange ? srcA[idx[IDX_W-1:0]] : 1'b0;
  end

  assign gatherW = {{(DATA_W-DIM){1'b0}}, pickedW};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ <= '0;
    end else if (ctrl.loadRes) begin
      resQ <= ctrl.pickGather ? gatherW : xposeW;
    end
  end

endmodule

// File: rtl/bmx_top.sv
module bmx_top
  import bmx_pkg::*;
#(
  parameter int DIM = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               op,
  input  logic [DIM*DIM-1:0] a,
  input  logic [DIM*DIM-1:0] b,
  output logic               done,
  output logic [DIM*DIM-1:0] result
);

  bmxCtrl_t ctrl;

  bmx_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opCode (bmxOp_e'(op)),
    .ctrl   (ctrl),
    .doneQ  (done)
  );

  bmx_datapath #(.DIM(DIM)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctrl (ctrl),
    .srcA (a),
    .srcB (b),
    .resQ (result)
  );

endmodule

// File: rtl/bmx_checker.sv
module bmx_checker #(
  parameter int DIM = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               op,
  input logic [DIM*DIM-1:0] a,
  input logic [DIM*DIM-1:0] b,
  input logic               done,
  input logic [DIM*DIM-1:0] result
);

  localparam int DATA_W = DIM * DIM;

  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done); // R2
  AST_DONE_ONLY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done); // R2
  AST_XPOSE_OFFDIAG: assert property (@(posedge clk) disable iff (!rstN)
    (start && !op) |=> (result[DIM] == $past(a[1])) && (result[1] == $past(a[DIM]))); // R3
  AST_GATHER_LANE0: assert property (@(posedge clk) disable iff (!rstN)
    (start && op && (b[DIM-1:0] == '0)) |=> (result[0] == $past(a[0]))); // R5
  AST_GATHER_OOR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (start && op && (int'(b[DIM-1:0]) >= DATA_W)) |=> !result[0]); // R6
  AST_GATHER_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (start && op) |=> (result[DATA_W-1:DIM] == '0)); // R7
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(result)); // R8

endmodule

bind bmx_top bmx_checker #(.DIM(DIM)) u_chk (.*);

// File: tb/sim_bmx_top.sv
`timescale 1ns/1ps
module sim_bmx_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        done;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  bmx_top #(.DIM(8)) u0 (.*);

  function automatic logic [63:0] refXpose(input logic [63:0] v);
    logic [63:0] o;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        o[8*j+i] = v[8*i+j];
    return o;
  endfunction

  function automatic logic [63:0] refGather(input logic [63:0] s, input logic [63:0] ix);
    logic [63:0] o = '0;
    for (int k = 0; k < 8; k++) begin
      int n = int'(ix[8*k +: 8]);
      o[k] = (n < 64) ? s[n] : 1'b0;
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // issue at a falling edge, sample at the next falling edge
  task automatic issue(input logic o, input logic [63:0] va, input logic [63:0] vb);
    @(negedge clk);
    op = o; a = va; b = vb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 done pulse", 64'(done), 64'd1);
  endtask

  task automatic t_reset();
    check("R1 result at reset", result, '0);
    check("R1 done at reset", 64'(done), '0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 result after reset", result, '0);
    check("R2 no done idle", 64'(done), '0);
  endtask

  task automatic t_xposeKnown();
    issue(1'b0, 64'h0000_0000_0000_00FF, '0);
    check("R3 row0 full", result, 64'h0101_0101_0101_0101);
    issue(1'b0, 64'h0101_0101_0101_0101, '0);
    check("R3 col0 full", result, 64'h0000_0000_0000_00FF);
    issue(1'b0, 64'h8040_2010_0804_0201, '0);
    check("R3 diagonal", result, 64'h8040_2010_0804_0201);
    issue(1'b0, 64'h0000_0000_0000_0002, '0);
    check("R3 single bit", result, 64'h0000_0000_0000_0100);
  endtask

  task automatic t_xposeRandom();
    for (int n = 0; n < 20; n++) begin
      logic [63:0] v = {$urandom, $urandom};
      logic [63:0] first;
      issue(1'b0, v, {$urandom, $urandom});
      check("R3 random", result, refXpose(v));
      first = result;
      issue(1'b0, first, {$urandom, $urandom});
      check("R4 double transpose", result, v);
      issue(1'b0, v, ~first);
      check("R9 b ignored", result, first);
    end
  endtask

  task automatic t_gatherRange();
    for (int n = 0; n < 30; n++) begin
      logic [63:0] s = {$urandom, $urandom};
      logic [63:0] ix;
      for (int k = 0; k < 8; k++) ix[8*k +: 8] = 8'($urandom_range(0, 63));
      issue(1'b1, s, ix);
      check("R5 gather in range", result, refGather(s, ix));
      check("R7 upper zero", result & 64'hFFFF_FFFF_FFFF_FF00, '0);
    end
  endtask

  task automatic t_gatherOutOfRange();
    issue(1'b1, '1, 64'h4040_7F7F_8080_FFFF);
    check("R6 all out of range", result, '0);
    issue(1'b1, '1, 64'h003F_1040_7F80_FF05);
    check("R6 mixed aliasing", result, 64'h0000_0000_0000_00E1);
    for (int n = 0; n < 30; n++) begin
      logic [63:0] s = {$urandom, $urandom};
      logic [63:0] ix = {$urandom, $urandom};
      issue(1'b1, s, ix);
      check("R6 random mixed", result, refGather(s, ix));
    end
  endtask

  task automatic t_hold();
    logic [63:0] keep;
    issue(1'b1, 64'hFFFF_0000_FFFF_0000, 64'h0706_0504_0302_0100);
    check("R5 ramp indices", result, 64'h0000_0000_0000_0000);
    issue(1'b0, 64'h1234_5678_9ABC_DEF0, '0);
    keep = result;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      op = n[0]; a = {$urandom, $urandom}; b = {$urandom, $urandom};
      @(negedge clk);
      check("R8 hold when idle", result, keep);
      check("R2 done low when idle", 64'(done), '0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_xposeKnown();
    t_xposeRandom();
    t_gatherRange();
    t_gatherOutOfRange();
    t_hold();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule